// File: doc/BRIEF.md
# Runt Pulse Detector

The detector watches two comparator outputs that have already been synchronized to the system clock. One says the input is above a lower level, the other says it is above an upper level. The two levels are set independently of each other. The block finds runt pulses. A runt is an excursion that crosses one level and falls back across that same level without ever reaching the other one. It produces a single-cycle trigger for each runt it accepts.

Two copies of one sequence tracker run side by side. The positive lane starts its sequence when the input rises past the lower level. The negative lane starts when the input drops below the upper level. A polarity select arms either lane or both. An excursion that does reach the far level counts as a normal pulse: the lane then waits for the input to return and raises no trigger.

Two optional qualifiers gate each runt before it becomes a trigger. The time qualifier accepts only runts longer than a programmed number of clock cycles. The logic qualifier accepts a runt only when an external logic-state input is true at the moment the runt ends.

Top module: `runt_detector`

## Requirements
- R1: While `rst` is high, `trig` is 0. After reset, a lane arms only once it has seen its baseline. For the positive lane that is `cmp_lo`=0; for the negative lane it is `cmp_hi`=1. A crossing back over the first level with no baseline seen first raises no trigger.
- R2: Positive runt: `cmp_lo` goes 1 and then returns to 0 while `cmp_hi` stays 0. `trig` is then high for the clock cycle after the edge that samples `cmp_lo`=0.
- R3: Negative runt: `cmp_hi` goes 0 and then returns to 1 while `cmp_lo` stays 1. `trig` is then high for the clock cycle after the edge that samples `cmp_hi`=1.
- R4: An excursion that reaches the far level gives no trigger. It stays a normal pulse until the input has returned across the first level and a new excursion begins.
- R5: `pol_sel` bit 0 arms the positive lane and bit 1 arms the negative lane. So 2'b01 is positive only, 2'b10 negative only, 2'b11 both, and 2'b00 none. A disarmed lane never triggers, and it must see its baseline again once re-armed.
- R6: With `tq_en`=1, a runt triggers only if its length is strictly greater than `tq_limit`. The length is the number of clock edges that sampled the first level as crossed. A length equal to the limit does not trigger.
- R7: With `tq_en`=0, a runt of any length, including a single cycle, triggers.
- R8: With `lq_en`=1, a runt triggers only if `lq_ok` is 1 at the edge that samples the end of the runt.
- R9: `trig` never stays high for two cycles in a row. The length count saturates at 2**CNT_W-1, so a very long runt triggers against a limit of 2**CNT_W-2 but not against 2**CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_lo | input | 1 | 1 when the signal is above the lower level |
| cmp_hi | input | 1 | 1 when the signal is above the upper level |
| pol_sel | input | 2 | Lane arm bits: bit 0 positive, bit 1 negative |
| tq_en | input | 1 | Enable the time qualifier |
| tq_limit | input | CNT_W | Runt length must exceed this many cycles |
| lq_en | input | 1 | Enable the logic-state qualifier |
| lq_ok | input | 1 | Logic-state condition from the other channels |
| trig | output | 1 | Registered single-cycle trigger |

## Verification
Two situations are the hardest to reach from the ports. The first is the length counter at saturation, because it needs a runt held for more cycles than the counter can represent. The bench therefore builds the block with a narrow counter and holds a positive runt for 300 cycles, once against the largest limit and once against one below it. The second is a lane's missing-baseline state. The bench reaches it by applying reset while the input sits between the levels and then letting the input fall, and by re-arming a lane through `pol_sel` in the middle of a sequence.

// File: rtl/runt_pkg.sv
package runt_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,  // baseline not yet observed
    ST_BASE  = 2'd1,  // on the baseline side of the first level
    ST_PULSE = 2'd2,  // first level crossed, far level not reached
    ST_FULL  = 2'd3   // far level reached: normal pulse
  } runt_st_e;

  localparam int NUM_LANES = 2;
  localparam int LANE_POS  = 0;
  localparam int LANE_NEG  = 1;
endpackage

// File: rtl/runt_seq.sv
module runt_seq
  import runt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             first,
  input  logic             second,
  output logic             ev,
  output logic [CNT_W-1:0] len
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  runt_st_e         state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      state <= ST_WAIT;
      cnt   <= '0;
    end else begin
      case (state)
        ST_WAIT: if (!first) state <= ST_BASE;
        ST_BASE: begin
          if (first) begin
            if (second) begin
              state <= ST_FULL;
            end else begin
              state <= ST_PULSE;
              cnt   <= {{(CNT_W-1){1'b0}}, 1'b1};
            end
          end
        end
        ST_PULSE: begin
          if (second)      state <= ST_FULL;
          else if (!first) state <= ST_BASE;
          else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
        ST_FULL: if (!first) state <= ST_BASE;
        default: state <= ST_WAIT;
      endcase
    end
  end

  assign ev  = arm && (state == ST_PULSE) && !second && !first;
  assign len = cnt;

  // R6: a tracked runt always has a nonzero length
  p_len_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PULSE) |-> (cnt != '0));

  // R4: once the far level is reached no runt can be in progress next cycle
  p_no_runt_after_full_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FULL) |=> (state != ST_PULSE));
endmodule

// File: rtl/runt_qual.sv
module runt_qual
  import runt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_i  [NUM_LANES],
  input  logic [CNT_W-1:0] len_i [NUM_LANES],
  input  logic             tq_en,
  input  logic [CNT_W-1:0] tq_limit,
  input  logic             lq_en,
  input  logic             lq_ok,
  output logic             trig
);
  logic [NUM_LANES-1:0] hit;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign hit[g] = ev_i[g] && (!tq_en || (len_i[g] > tq_limit))
                            && (!lq_en || lq_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) trig <= 1'b0;
    else     trig <= |hit;
  end

  // R8: a trigger under logic qualification needs the logic state true
  p_logic_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (trig && $past(lq_en)) |-> $past(lq_ok));

  // R6: a trigger under time qualification needs a runt longer than the limit
  p_time_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (trig && $past(tq_en)) |->
      $past((ev_i[LANE_POS] && (len_i[LANE_POS] > tq_limit)) ||
            (ev_i[LANE_NEG] && (len_i[LANE_NEG] > tq_limit))));

  // R9: the trigger lasts a single cycle
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);
endmodule

// File: rtl/runt_detector.sv
module runt_detector
  import runt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_lo,
  input  logic             cmp_hi,
  input  logic [1:0]       pol_sel,
  input  logic             tq_en,
  input  logic [CNT_W-1:0] tq_limit,
  input  logic             lq_en,
  input  logic             lq_ok,
  output logic             trig
);
  logic             lane_ev  [NUM_LANES];
  logic [CNT_W-1:0] lane_len [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic first_w, second_w;
    if (g == LANE_POS) begin : g_pos
      // rising out of the low region: first = above low, far = above high
      assign first_w  = cmp_lo;
      assign second_w = cmp_hi;
    end else begin : g_neg
      // falling out of the high region: first = below high, far = below low
      assign first_w  = ~cmp_hi;
      assign second_w = ~cmp_lo;
    end

    runt_seq #(.CNT_W(CNT_W)) u_seq (
      .clk    (clk),
      .rst    (rst),
      .arm    (pol_sel[g]),
      .first  (first_w),
      .second (second_w),
      .ev     (lane_ev[g]),
      .len    (lane_len[g])
    );
  end

  runt_qual #(.CNT_W(CNT_W)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .ev_i     (lane_ev),
    .len_i    (lane_len),
    .tq_en    (tq_en),
    .tq_limit (tq_limit),
    .lq_en    (lq_en),
    .lq_ok    (lq_ok),
    .trig     (trig)
  );

  // R5: nothing fires when both lanes were disarmed
  p_pol_gate_r5: assert property (@(posedge clk) disable iff (rst)
    trig |-> ($past(pol_sel) != 2'b00));
endmodule

// File: tb/tb_runt_detector.sv
`timescale 1ns/1ps
module tb_runt_detector;
  localparam int CNT_W = 8;
  localparam logic [1:0] POL_NONE = 2'b00, POL_POS = 2'b01,
                         POL_NEG = 2'b10, POL_BOTH = 2'b11;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmp_lo = 1'b0, cmp_hi = 1'b0;
  logic [1:0]       pol_sel = POL_BOTH;
  logic             tq_en = 1'b0, lq_en = 1'b0, lq_ok = 1'b0;
  logic [CNT_W-1:0] tq_limit = '0;
  logic             trig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  runt_detector #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .pol_sel(pol_sel), .tq_en(tq_en), .tq_limit(tq_limit),
    .lq_en(lq_en), .lq_ok(lq_ok), .trig(trig)
  );

  // {cmp_lo, cmp_hi, expected trig}; polarity both, no qualifiers
  // steps 0-4: positive runt (R2); 5-9: normal rise then negative runt (R3)
  // steps 10-12: far level reached, normal pulse (R4); 13-18: mixed
  localparam logic [2:0] TBL [19] = '{
    3'b000, 3'b100, 3'b100, 3'b001, 3'b000,
    3'b100, 3'b110, 3'b110, 3'b100, 3'b111,
    3'b100, 3'b000, 3'b000, 3'b100, 3'b001,
    3'b100, 3'b110, 3'b000, 3'b000
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: trig=%0b expected %0b", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge sample, check at next fall
  task automatic step(input logic lo, input logic hi, input logic exp,
                      input string tag);
    cmp_lo = lo;
    cmp_hi = hi;
    @(posedge clk);
    @(negedge clk);
    chk(trig, exp, tag);
  endtask

  // positive runt from the low baseline: len cycles above low, then back
  task automatic pos_runt(input int len, input logic exp, input string tag);
    for (int i = 0; i < len; i++) step(1'b1, 1'b0, 1'b0, tag);
    step(1'b0, 1'b0, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(trig, 1'b0, "R1 reset value");
    rst = 1'b0;

    for (int i = 0; i < 19; i++) begin
      step(TBL[i][2], TBL[i][1], TBL[i][0],
           $sformatf("R2/R3/R4 table step %0d", i));
    end

    // R5: positive only, a negative runt is ignored
    pol_sel = POL_POS;
    step(1'b1, 1'b1, 1'b0, "R5 pos-only setup");
    step(1'b1, 1'b0, 1'b0, "R5 pos-only neg dip");
    step(1'b1, 1'b1, 1'b0, "R5 pos-only neg runt ignored");
    step(1'b0, 1'b0, 1'b0, "R5 pos-only return");
    // R5: negative only, a positive runt is ignored, then a negative one fires
    pol_sel = POL_NEG;
    pos_runt(2, 1'b0, "R5 neg-only pos runt ignored");
    step(1'b1, 1'b1, 1'b0, "R5 neg-only baseline");
    step(1'b1, 1'b0, 1'b0, "R5 neg-only dip");
    step(1'b1, 1'b1, 1'b1, "R5 R3 neg-only runt fires");
    step(1'b1, 1'b1, 1'b0, "R9 one cycle only");
    // R5: none armed
    pol_sel = POL_NONE;
    step(1'b1, 1'b0, 1'b0, "R5 none dip");
    step(1'b1, 1'b1, 1'b0, "R5 none runt ignored");

    // R1: reset between levels, then falling back: no baseline, no trigger
    pol_sel = POL_BOTH;
    cmp_lo = 1'b1; cmp_hi = 1'b0;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(trig, 1'b0, "R1 trig low in reset");
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    step(1'b1, 1'b0, 1'b0, "R1 no baseline yet");
    step(1'b0, 1'b0, 1'b0, "R1 fall without baseline");

    // R6: time qualification, limit 3
    pol_sel = POL_POS;
    step(1'b0, 1'b0, 1'b0, "R6 baseline");
    tq_en = 1'b1; tq_limit = 8'd3;
    pos_runt(3, 1'b0, "R6 length equal limit");
    pos_runt(4, 1'b1, "R6 length above limit");
    // R7: time qualification off, single-cycle runt
    tq_en = 1'b0;
    pos_runt(1, 1'b1, "R7 one-cycle runt");

    // R8: logic qualification
    lq_en = 1'b1;
    lq_ok = 1'b1;
    step(1'b1, 1'b0, 1'b0, "R8 start ok high");
    lq_ok = 1'b0;
    step(1'b0, 1'b0, 1'b0, "R8 end ok low");
    lq_ok = 1'b0;
    step(1'b1, 1'b0, 1'b0, "R8 start ok low");
    lq_ok = 1'b1;
    step(1'b0, 1'b0, 1'b1, "R8 end ok high");
    lq_en = 1'b0; lq_ok = 1'b0;

    // R9: saturating length against the largest limits
    tq_en = 1'b1; tq_limit = 8'd255;
    pos_runt(300, 1'b0, "R9 saturated vs max limit");
    tq_limit = 8'd254;
    pos_runt(300, 1'b1, "R9 saturated vs max-1 limit");
    step(1'b0, 1'b0, 1'b0, "R9 single cycle after saturation");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule